// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device end of a two-port byte-wide host interface to an embedded controller. The host sees a data port at offset 0 and a combined status/command port at offset 4. It writes command bytes to the command port and moves address and data bytes through the data port. A flag handshake paces each transfer. An input-full flag tells the host that its last byte has not yet been taken. An output-full flag tells it that a reply byte is waiting. Behind the ports, a small sequencer decodes the commands and reads or writes a private register space of 2^REG_AW bytes.

Each byte the host writes is held in one latch for CONSUME_CYCLES clock cycles before the sequencer takes it. The delay is visible on the input-full flag, so host software that skips the handshake loses bytes. The supported commands are:

- register read;
- register write;
- burst flag set;
- burst flag clear;
- a query that always answers zero.

Two event-pending status bits show two test inputs. No interrupts are generated.

Top module: `ec_host_port`

## Requirements
- R1: Only offsets 0 and 4 are decoded. A read of offset 4 returns the status byte, a read of offset 0 returns the output data register, and any other offset reads 0x00. Writes to other offsets change nothing: the input-full flag stays clear.
- R2: Every write to offset 0 or 4 sets the input-full flag (status bit 1). The flag stays set for exactly CONSUME_CYCLES cycles (default 4) and then clears as the byte is consumed. A write that arrives while the flag is set replaces the held byte, which is lost, and restarts the count.
- R3: Status bit 3 is set by a write to offset 4 and cleared by a write to offset 0. It holds its value between writes.
- R4: Command 0x80 followed by an address byte on offset 0 loads the addressed register into the output data register once the address byte is consumed. In the same cycle the output-full flag (status bit 0) sets.
- R5: A host read of offset 0 clears the output-full flag on the following clock edge.
- R6: Command 0x81 followed by an address byte and then a value byte on offset 0 stores the value at that address. Addresses 0x00 and 0xFF are both valid.
- R7: Command 0x82 sets the burst flag (status bit 4). Command 0x83 clears it.
- R8: Command 0x84 loads 0x00 into the output data register and sets the output-full flag.
- R9: A command byte consumed in the middle of a sequence abandons that sequence. Bytes with any code other than 0x80 to 0x84 start nothing, and a data byte consumed with no sequence open is ignored. Neither changes the register space or the output-full flag.
- R10: Status bit 2 follows the sci_evt input and status bit 5 follows the smi_evt input. Status bits 7 and 6 read as zero.
- R11: After reset the status byte, the output data register and the burst flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | HOST_AW | Host byte offset (0 = data, 4 = status/command) |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the offset on host_addr |
| sci_evt | input | 1 | Test input shown as status bit 2 |
| smi_evt | input | 1 | Test input shown as status bit 5 |

## Verification
The assertions check the following on every cycle:
- a decoded write raises input-full;
- input-full drops when its count runs out;
- writes outside the two offsets leave it clear;
- the command flag follows the port written;
- a consumed read address or a query raises output-full;
- a data-port read clears output-full;
- the burst commands move the burst flag;
- a consumed command closes any open sequence.

Only the bench scenarios can show the end-to-end effects:
- register contents surviving an aborted write;
- a stray data byte being ignored;
- the overwrite loss when the handshake is skipped;
- the exact handshake duration.

To cover these, the bench uses a behavioural model that is compared on every clock.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // command codes
  localparam byte_t CMD_REG_READ  = 8'h80;
  localparam byte_t CMD_REG_WRITE = 8'h81;
  localparam byte_t CMD_BURST_ON  = 8'h82;
  localparam byte_t CMD_BURST_OFF = 8'h83;
  localparam byte_t CMD_QUERY     = 8'h84;

  // status bit positions
  localparam int ST_OBF   = 0;
  localparam int ST_IBF   = 1;
  localparam int ST_SCI   = 2;
  localparam int ST_CMD   = 3;
  localparam int ST_BURST = 4;
  localparam int ST_SMI   = 5;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_RD_ADDR = 2'd1,
    SQ_WR_ADDR = 2'd2,
    SQ_WR_DATA = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic  is_cmd;
    byte_t val;
  } in_byte_t;

endpackage

// File: rtl/ecp_inbuf.sv
module ecp_inbuf
  import ecp_pkg::*;
#(
  parameter int CONSUME_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     wr_is_cmd,
  input  byte_t    wr_data,
  output logic     ibf,
  output logic     cmd_flag,
  output logic     consume,
  output in_byte_t cons_byte
);

  localparam int CNT_W = (CONSUME_CYCLES > 1) ? $clog2(CONSUME_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONSUME_CYCLES - 1);

  logic             ibf_q, ibf_d;
  logic             cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  in_byte_t         hold_q;

  // next state
  always_comb begin
    ibf_d   = ibf_q;
    cmd_d   = cmd_q;
    cnt_d   = cnt_q;
    consume = ibf_q && (cnt_q == '0) && !wr_en;
    if (wr_en) begin
      ibf_d = 1'b1;
      cnt_d = CNT_LOAD;
      cmd_d = wr_is_cmd;
    end else if (ibf_q) begin
      if (cnt_q == '0) begin
        ibf_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      cmd_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ibf_q <= ibf_d;
      cmd_q <= cmd_d;
      cnt_q <= cnt_d;
    end
  end

  // held byte, loaded under write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (wr_en) begin
      hold_q <= '{is_cmd: wr_is_cmd, val: wr_data};
    end
  end

  assign ibf       = ibf_q;
  assign cmd_flag  = cmd_q;
  assign cons_byte = hold_q;

  AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ibf_q); // R2
  AST_IBF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_q && (cnt_q == '0) && !wr_en) |=> !ibf_q); // R2
  AST_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cmd_q == $past(wr_is_cmd))); // R3

endmodule

// File: rtl/ecp_regfile.sv
module ecp_regfile
  import ecp_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  byte_t             wdata,
  input  logic [REG_AW-1:0] raddr,
  output byte_t             rdata
);

  localparam int DEPTH = 1 << REG_AW;

  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ecp_seq.sv
module ecp_seq
  import ecp_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume,
  input  in_byte_t          cons_byte,
  input  logic              host_rd_data,
  input  byte_t             mem_rdata,
  output logic [REG_AW-1:0] mem_raddr,
  output logic              mem_we,
  output logic [REG_AW-1:0] mem_waddr,
  output byte_t             mem_wdata,
  output logic              obf,
  output byte_t             out_data,
  output logic              burst
);

  seq_state_e        state_q, state_d;
  logic [REG_AW-1:0] addr_q, addr_d;
  logic              obf_q, obf_d;
  byte_t             out_q, out_d;
  logic              burst_q, burst_d;

  assign mem_raddr = cons_byte.val[REG_AW-1:0];

  // next state
  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    obf_d     = obf_q;
    out_d     = out_q;
    burst_d   = burst_q;
    mem_we    = 1'b0;
    mem_waddr = addr_q;
    mem_wdata = cons_byte.val;
    if (host_rd_data) begin
      obf_d = 1'b0;
    end
    if (consume) begin
      if (cons_byte.is_cmd) begin
        state_d = SQ_IDLE;
        case (cons_byte.val)
          CMD_REG_READ:  state_d = SQ_RD_ADDR;
          CMD_REG_WRITE: state_d = SQ_WR_ADDR;
          CMD_BURST_ON:  burst_d = 1'b1;
          CMD_BURST_OFF: burst_d = 1'b0;
          CMD_QUERY: begin
            out_d = '0;
            obf_d = 1'b1;
          end
          default: ;
        endcase
      end else begin
        case (state_q)
          SQ_RD_ADDR: begin
            out_d   = mem_rdata;
            obf_d   = 1'b1;
            state_d = SQ_IDLE;
          end
          SQ_WR_ADDR: begin
            addr_d  = cons_byte.val[REG_AW-1:0];
            state_d = SQ_WR_DATA;
          end
          SQ_WR_DATA: begin
            mem_we  = 1'b1;
            state_d = SQ_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      obf_q   <= 1'b0;
      out_q   <= '0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      obf_q   <= obf_d;
      out_q   <= out_d;
      burst_q <= burst_d;
    end
  end

  // write address, loaded only while a write sequence takes its address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (consume && !cons_byte.is_cmd && (state_q == SQ_WR_ADDR)) begin
      addr_q <= addr_d;
    end
  end

  assign obf      = obf_q;
  assign out_data = out_q;
  assign burst    = burst_q;

  AST_READ_OBF: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !cons_byte.is_cmd && state_q == SQ_RD_ADDR) |=> obf_q); // R4
  AST_HOST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data && !consume) |=> !obf_q); // R5
  AST_BURST_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && cons_byte.is_cmd && cons_byte.val == CMD_BURST_ON) |=> burst_q); // R7
  AST_BURST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && cons_byte.is_cmd && cons_byte.val == CMD_BURST_OFF) |=> !burst_q); // R7
  AST_QUERY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && cons_byte.is_cmd && cons_byte.val == CMD_QUERY) |=> (obf_q && out_q == '0)); // R8
  AST_CMD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && cons_byte.is_cmd && cons_byte.val != CMD_REG_READ
     && cons_byte.val != CMD_REG_WRITE) |=> (state_q == SQ_IDLE)); // R9

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ecp_pkg::*;
#(
  parameter int HOST_AW        = 3,
  parameter int REG_AW         = 8,
  parameter int CONSUME_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               sci_evt,
  input  logic               smi_evt
);

  localparam logic [HOST_AW-1:0] OFS_DATA = HOST_AW'(0);
  localparam logic [HOST_AW-1:0] OFS_CTRL = HOST_AW'(4);

  logic              sel_data, sel_ctrl;
  logic              wr_en, rd_data_stb;
  logic              ibf, cmd_flag, consume;
  in_byte_t          cons_byte;
  logic              obf, burst;
  byte_t             out_data;
  byte_t             status;
  logic              mem_we;
  logic [REG_AW-1:0] mem_waddr, mem_raddr;
  byte_t             mem_wdata, mem_rdata;

  assign sel_data    = (host_addr == OFS_DATA);
  assign sel_ctrl    = (host_addr == OFS_CTRL);
  assign wr_en       = host_wr && (sel_data || sel_ctrl);
  assign rd_data_stb = host_rd && sel_data;

  ecp_inbuf #(.CONSUME_CYCLES(CONSUME_CYCLES)) u_inbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_is_cmd (sel_ctrl),
    .wr_data   (host_wdata),
    .ibf       (ibf),
    .cmd_flag  (cmd_flag),
    .consume   (consume),
    .cons_byte (cons_byte)
  );

  ecp_seq #(.REG_AW(REG_AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .consume      (consume),
    .cons_byte    (cons_byte),
    .host_rd_data (rd_data_stb),
    .mem_rdata    (mem_rdata),
    .mem_raddr    (mem_raddr),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_wdata    (mem_wdata),
    .obf          (obf),
    .out_data     (out_data),
    .burst        (burst)
  );

  ecp_regfile #(.REG_AW(REG_AW)) u_regs (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  always_comb begin
    status           = '0;
    status[ST_OBF]   = obf;
    status[ST_IBF]   = ibf;
    status[ST_SCI]   = sci_evt;
    status[ST_CMD]   = cmd_flag;
    status[ST_BURST] = burst;
    status[ST_SMI]   = smi_evt;
  end

  always_comb begin
    if (sel_ctrl) begin
      host_rdata = status;
    end else if (sel_data) begin
      host_rdata = out_data;
    end else begin
      host_rdata = '0;
    end
  end

  AST_OFF_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !sel_data && !sel_ctrl && !ibf) |=> !ibf); // R1

endmodule

// File: tb/tb_ec_host_port.sv
module tb_ec_host_port;

  localparam int CLK_PERIOD = 10;
  localparam int CONSUME    = 4;
  localparam int WD_CYCLES  = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = 3'd4;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       sci_evt = 1'b0;
  logic       smi_evt = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ec_host_port #(.HOST_AW(3), .REG_AW(8), .CONSUME_CYCLES(CONSUME)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .sci_evt    (sci_evt),
    .smi_evt    (smi_evt)
  );

  // ---------------- behavioural reference model ----------------
  bit [7:0] m_mem [int];
  int       m_ibf_left = 0;   // cycles of input-full still to run; 0 = empty
  bit       m_ibf = 0;
  int       m_byte = 0;
  bit       m_is_cmd = 0;
  bit       m_cmdflag = 0;
  bit       m_obf = 0;
  int       m_out = 0;
  bit       m_burst = 0;
  string    m_mode = "idle";
  int       m_waddr = 0;

  function automatic void m_take(int b, bit is_cmd);
    if (is_cmd) begin
      m_mode = "idle";
      if (b == 'h80) m_mode = "rdaddr";
      else if (b == 'h81) m_mode = "wraddr";
      else if (b == 'h82) m_burst = 1;
      else if (b == 'h83) m_burst = 0;
      else if (b == 'h84) begin m_out = 0; m_obf = 1; end
    end else if (m_mode == "rdaddr") begin
      m_out  = m_mem.exists(b) ? int'(m_mem[b]) : 0;
      m_obf  = 1;
      m_mode = "idle";
    end else if (m_mode == "wraddr") begin
      m_waddr = b;
      m_mode  = "wrdata";
    end else if (m_mode == "wrdata") begin
      m_mem[m_waddr] = b[7:0];
      m_mode = "idle";
    end
  endfunction

  always @(posedge clk) begin
    bit wr;
    wr = host_wr && (host_addr == 3'd0 || host_addr == 3'd4);
    if (!rst_n) begin
      m_ibf = 0; m_ibf_left = 0; m_cmdflag = 0; m_obf = 0;
      m_out = 0; m_burst = 0; m_mode = "idle";
    end else begin
      if (host_rd && host_addr == 3'd0) m_obf = 0;
      if (m_ibf && !wr) begin
        m_ibf_left--;
        if (m_ibf_left == 0) begin
          m_ibf = 0;
          m_take(m_byte, m_is_cmd);
        end
      end
      if (wr) begin
        m_ibf = 1; m_ibf_left = CONSUME;
        m_byte = int'(host_wdata);
        m_is_cmd = (host_addr == 3'd4);
        m_cmdflag = m_is_cmd;
      end
    end
  end

  function automatic logic [7:0] m_status();
    return {2'b00, smi_evt, m_burst, m_cmdflag, sci_evt, m_ibf, m_obf};
  endfunction

  // per-cycle comparison of the read port against the model
  always @(negedge clk) begin
    logic [7:0] exp;
    if (rst_n) begin
      if (host_addr == 3'd4) exp = m_status();
      else if (host_addr == 3'd0) exp = m_out[7:0];
      else exp = 8'h00;
      checks++;
      if (host_rdata !== exp) begin
        errors++;
        $display("FAIL R1 per-cycle port compare at offset %0d: actual %02h expected %02h",
                 host_addr, host_rdata, exp);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_CYCLES) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic peek_status(output logic [7:0] v);
    @(posedge clk); #1 host_addr = 3'd4;
    @(negedge clk); v = host_rdata;
  endtask

  task automatic wait_ibf_clear();
    @(posedge clk); #1 host_addr = 3'd4;
    @(negedge clk);
    while (host_rdata[1]) @(negedge clk);
  endtask

  task automatic host_write(bit ctrl, logic [7:0] v);
    wait_ibf_clear();
    @(posedge clk); #1 host_addr = ctrl ? 3'd4 : 3'd0; host_wr = 1'b1; host_wdata = v;
    @(posedge clk); #1 host_wr = 1'b0; host_addr = 3'd4;
  endtask

  task automatic host_read_data(output logic [7:0] v);
    @(posedge clk); #1 host_addr = 3'd4;
    @(negedge clk);
    while (!host_rdata[0]) @(negedge clk);
    @(posedge clk); #1 host_addr = 3'd0; host_rd = 1'b1;
    @(negedge clk); v = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0; host_addr = 3'd4;
  endtask

  task automatic ec_write(logic [7:0] a, logic [7:0] v);
    host_write(1'b1, 8'h81);
    host_write(1'b0, a);
    host_write(1'b0, v);
    wait_ibf_clear();
  endtask

  task automatic ec_read(logic [7:0] a, output logic [7:0] v);
    host_write(1'b1, 8'h80);
    host_write(1'b0, a);
    host_read_data(v);
  endtask

  task automatic count_ibf(output int n);
    n = 0;
    @(negedge clk);
    while (host_rdata[1]) begin n++; @(negedge clk); end
  endtask

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0] v;
    int n;

    repeat (3) @(posedge clk);
    #1 host_addr = 3'd4;
    @(negedge clk);
    chk("R11", "status after reset", host_rdata, 8'h00);
    #1 host_addr = 3'd0;
    @(negedge clk);
    chk("R11", "data register after reset", host_rdata, 8'h00);
    @(posedge clk); #1 rst_n = 1'b1; host_addr = 3'd4;

    // R2 / R3: handshake duration and command flag
    @(posedge clk); #1 host_addr = 3'd4; host_wr = 1'b1; host_wdata = 8'h83;
    @(posedge clk); #1 host_wr = 1'b0;
    @(negedge clk);
    chk("R3", "command flag after command write", {7'd0, host_rdata[3]}, 8'h01);
    n = 1;
    @(negedge clk);
    while (host_rdata[1]) begin n++; @(negedge clk); end
    chk("R2", "input-full duration", 8'(n), 8'(CONSUME));

    // R6 / R4 / R5: write, read back, output-full handling
    ec_write(8'h10, 8'h5A);
    host_write(1'b1, 8'h80);
    host_write(1'b0, 8'h10);
    wait_ibf_clear();
    peek_status(v);
    chk("R4", "output-full after read sequence", {7'd0, v[0]}, 8'h01);
    chk("R3", "command flag after data write", {7'd0, v[3]}, 8'h00);
    host_read_data(v);
    chk("R4", "read data 0x10", v, 8'h5A);
    peek_status(v);
    chk("R5", "output-full after host read", {7'd0, v[0]}, 8'h00);

    // R6: boundary addresses and a spread of patterns
    ec_write(8'h00, 8'hA5);
    ec_write(8'hFF, 8'h3C);
    ec_read(8'h00, v);
    chk("R6", "register 0x00", v, 8'hA5);
    ec_read(8'hFF, v);
    chk("R6", "register 0xFF", v, 8'h3C);
    for (int i = 1; i < 9; i++) ec_write(8'(i * 29), 8'(i * 37 + 3));
    for (int i = 1; i < 9; i++) begin
      ec_read(8'(i * 29), v);
      chk("R6", "pattern readback", v, 8'(i * 37 + 3));
    end

    // R7: burst flag
    host_write(1'b1, 8'h82);
    wait_ibf_clear();
    peek_status(v);
    chk("R7", "burst bit after 0x82", {7'd0, v[4]}, 8'h01);
    host_write(1'b1, 8'h83);
    wait_ibf_clear();
    peek_status(v);
    chk("R7", "burst bit after 0x83", {7'd0, v[4]}, 8'h00);

    // R8: query answers zero (data register holds a nonzero value before it)
    host_write(1'b1, 8'h84);
    host_read_data(v);
    chk("R8", "query reply", v, 8'h00);

    // R9: read command aborts an open write sequence
    ec_write(8'h20, 8'h44);
    host_write(1'b1, 8'h81);
    host_write(1'b0, 8'h20);
    host_write(1'b1, 8'h80);
    host_write(1'b0, 8'h20);
    host_read_data(v);
    chk("R9", "aborted write left register 0x20", v, 8'h44);

    // R9: unknown command aborts; trailing data byte ignored
    ec_write(8'h30, 8'hC3);
    host_write(1'b1, 8'h81);
    host_write(1'b0, 8'h30);
    host_write(1'b1, 8'h99);
    host_write(1'b0, 8'h11);
    wait_ibf_clear();
    peek_status(v);
    chk("R9", "output-full after stray data", {7'd0, v[0]}, 8'h00);
    ec_read(8'h30, v);
    chk("R9", "register 0x30 after unknown command", v, 8'hC3);

    // R9: data byte with no sequence open
    host_write(1'b0, 8'h77);
    wait_ibf_clear();
    peek_status(v);
    chk("R9", "output-full after idle data byte", {7'd0, v[0]}, 8'h00);
    ec_read(8'h10, v);
    chk("R9", "register 0x10 after idle data byte", v, 8'h5A);

    // R2: overwrite while input-full is set loses the first byte
    wait_ibf_clear();
    @(posedge clk); #1 host_addr = 3'd4; host_wr = 1'b1; host_wdata = 8'h80;
    @(posedge clk); #1 host_addr = 3'd0; host_wdata = 8'h10;
    @(posedge clk); #1 host_wr = 1'b0; host_addr = 3'd4;
    count_ibf(n);
    chk("R2", "input-full duration after overwrite", 8'(n), 8'(CONSUME));
    repeat (2) @(negedge clk);
    chk("R2", "output-full after lost command", {7'd0, host_rdata[0]}, 8'h00);

    // R1: undecoded offsets
    @(posedge clk); #1 host_addr = 3'd1; host_wr = 1'b1; host_wdata = 8'h82;
    @(posedge clk); #1 host_wr = 1'b0; host_addr = 3'd4;
    @(negedge clk);
    chk("R1", "input-full after write to offset 1", {7'd0, host_rdata[1]}, 8'h00);
    repeat (CONSUME + 2) @(negedge clk);
    chk("R1", "burst bit after write to offset 1", {7'd0, host_rdata[4]}, 8'h00);
    @(posedge clk); #1 host_addr = 3'd2;
    @(negedge clk);
    chk("R1", "read of offset 2", host_rdata, 8'h00);

    // R10: event inputs
    @(posedge clk); #1 host_addr = 3'd4; sci_evt = 1'b1;
    @(negedge clk);
    chk("R10", "status with sci only", host_rdata & 8'hE4, 8'h04);
    @(posedge clk); #1 sci_evt = 1'b0; smi_evt = 1'b1;
    @(negedge clk);
    chk("R10", "status with smi only", host_rdata & 8'hE4, 8'h20);
    @(posedge clk); #1 smi_evt = 1'b0;

    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule